// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits beside the register file of a 16550-style serial port and decides which interrupt, if any, the port reports. It takes four source conditions: line-status error events, a receive-data condition (data ready or FIFO trigger reached), the transmit-holding-register empty level, and modem-status delta events. It gates them with the 4-bit enable register, ranks the enabled ones by fixed priority, and presents the winner as an 8-bit identification byte. The interrupt line is asserted whenever that byte reports a pending source.

Each source leaves the pending state through its own side effect. A read of the line-status register clears the line-status source. A read of the modem-status register clears the modem source. A read of the receive buffer retires the data source. The transmit-empty source is retired by a write to the holding register, or by a read of the identification byte while that byte reports transmit-empty. The two top bits of the identification byte show that FIFO mode is on. The serial shifters, the baud generator and the FIFOs are outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted and after it is released with the enable register at zero, `ident_q` reads 0x01 and `irq` is 0. All pending state is clear.
- R2: Bits 3:0 of `ident_q` carry the code of the highest-priority enabled pending source: line status 0x6, received data 0x4, transmit empty 0x2, modem status 0x0. They read 0x1 when nothing is pending. The priority is line status, then received data, then transmit empty, then modem status.
- R3: Bits 7:6 of `ident_q` are both 1 while `fifo_on` is 1 and both 0 otherwise. Bits 5:4 are always 0.
- R4: Enable bit 0 admits received data, bit 1 admits transmit empty, bit 2 admits line status and bit 3 admits modem status. A disabled source is hidden from `ident_q`, but its pending state is kept, so it shows again when it is re-enabled.
- R5: A cycle with `line_err_evt` high makes line status pending from the next edge on. It stays pending until a cycle with `line_rd` high. If the event and the read fall in the same cycle, the source stays pending.
- R6: A cycle with `modem_delta_evt` high makes modem status pending from the next edge on. It stays pending until a cycle with `modem_rd` high. If the event and the read fall in the same cycle, the source stays pending.
- R7: Received data becomes pending at the edge after a cycle with `rx_avail` high, and it stays pending even if `rx_avail` falls. A cycle with `rbr_rd` high clears it at the next edge, and the read wins over a same-cycle `rx_avail`. If `rx_avail` is still high afterwards, the source is pending again one edge later.
- R8: Transmit empty becomes pending at an edge where `thr_empty` is 1 and either it was 0 at the previous edge (the first edge after reset counts as such a change), or enable bit 1 was 0 at the previous edge and is now 1. It is cleared by `thr_wr`, by `thr_empty` being 0, or by `ident_rd` in a cycle where bits 3:0 of `ident_q` read 0x2. A same-cycle set wins over these clears.
- R9: A cycle with `ident_rd` high while `ident_q` reports any code other than 0x2 leaves a pending transmit-empty source pending.
- R10: `irq` is 1 exactly when bit 0 of `ident_q` is 0, that is, when at least one enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_q | input | 4 | Interrupt enable register contents |
| line_err_evt | input | 1 | Line-status error event (overrun, parity, framing, break) |
| rx_avail | input | 1 | Receive data ready, or FIFO trigger level reached |
| thr_empty | input | 1 | Transmit holding register is empty (level) |
| modem_delta_evt | input | 1 | Modem-status delta event |
| fifo_on | input | 1 | FIFO mode enabled |
| ident_rd | input | 1 | Read strobe of the identification register |
| line_rd | input | 1 | Read strobe of the line-status register |
| rbr_rd | input | 1 | Read strobe of the receive buffer |
| modem_rd | input | 1 | Read strobe of the modem-status register |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| ident_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that every strobe and event input is a clean 0 or 1 that is sampled once per clock edge. They make no assumption about spacing: two read strobes, or a clearing strobe and the matching event, may arrive in the same cycle. The checks that relate transmit-empty clearing to the reported code assume that `ident_rd` is sampled against the byte visible in that same cycle. The bench drives every input a fixed delay after the rising edge and holds it for the whole cycle. Its random phase deliberately sends strobes in the same cycle as their events, toggles the enables and the FIFO bit freely, and keeps `thr_empty` mostly high so that the transmit source keeps re-arming.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N   = 4;
  localparam int IER_W   = 4;
  localparam int IDENT_W = 8;
  localparam int CODE_W  = 4;

  // source bit positions, aligned with the enable register
  localparam int SRC_RXD  = 0;
  localparam int SRC_TXE  = 1;
  localparam int SRC_LINE = 2;
  localparam int SRC_MDM  = 3;

  localparam logic [CODE_W-1:0] ID_NONE = 4'h1;
  localparam logic [CODE_W-1:0] ID_LINE = 4'h6;
  localparam logic [CODE_W-1:0] ID_RXD  = 4'h4;
  localparam logic [CODE_W-1:0] ID_TXE  = 4'h2;
  localparam logic [CODE_W-1:0] ID_MDM  = 4'h0;

  // fixed priority: line, received data, transmit empty, modem
  function automatic logic [CODE_W-1:0] rank_id(input logic [SRC_N-1:0] live);
    logic [CODE_W-1:0] id;
    if (live[SRC_LINE])     id = ID_LINE;
    else if (live[SRC_RXD]) id = ID_RXD;
    else if (live[SRC_TXE]) id = ID_TXE;
    else if (live[SRC_MDM]) id = ID_MDM;
    else                    id = ID_NONE;
    return id;
  endfunction

  function automatic logic [IDENT_W-1:0] make_ident(input logic fifo,
                                                    input logic [CODE_W-1:0] id);
    return {fifo, fifo, 2'b00, id};
  endfunction
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  generate
    if (SET_WINS) begin : g_set_wins
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
      end
    end else begin : g_clr_wins
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (clr_i) flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic en_i,
  input  logic wr_i,
  input  logic id_rd_i,
  input  logic shown_i,
  output logic pend_o,
  output logic set_o
);
  logic prev_empty_q;
  logic prev_en_q;
  logic clr;

  // arm on a move to empty, or on the enable turning on while empty
  assign set_o = empty_i & (~prev_empty_q | (en_i & ~prev_en_q));
  assign clr   = wr_i | ~empty_i | (id_rd_i & shown_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_empty_q <= 1'b0;
      prev_en_q    <= 1'b0;
      pend_o       <= 1'b0;
    end else begin
      prev_empty_q <= empty_i;
      prev_en_q    <= en_i;
      if (set_o)    pend_o <= 1'b1;
      else if (clr) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_rank.sv
module uart_irq_rank
  import uart_irq_pkg::*;
(
  input  logic [IER_W-1:0]   en_i,
  input  logic [SRC_N-1:0]   raw_i,
  input  logic               fifo_i,
  output logic [SRC_N-1:0]   live_o,
  output logic [IDENT_W-1:0] ident_o
);
  always_comb begin
    live_o  = raw_i & en_i;
    ident_o = make_ident(fifo_i, rank_id(live_o));
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IER_W-1:0]   ier_q,
  input  logic               line_err_evt,
  input  logic               rx_avail,
  input  logic               thr_empty,
  input  logic               modem_delta_evt,
  input  logic               fifo_on,
  input  logic               ident_rd,
  input  logic               line_rd,
  input  logic               rbr_rd,
  input  logic               modem_rd,
  input  logic               thr_wr,
  output logic [IDENT_W-1:0] ident_q,
  output logic               irq
);
  // sticky sources: 0 line status, 1 modem delta, 2 received data
  localparam int STK_N = 3;

  logic [STK_N-1:0] stk_set;
  logic [STK_N-1:0] stk_clr;
  logic [STK_N-1:0] stk_q;
  logic [SRC_N-1:0] raw_pend;
  logic [SRC_N-1:0] live_pend;
  logic             txe_pend;
  logic             txe_set;
  logic             txe_shown;

  assign stk_set = {rx_avail, modem_delta_evt, line_err_evt};
  assign stk_clr = {rbr_rd, modem_rd, line_rd};

  genvar g;
  generate
    for (g = 0; g < STK_N; g++) begin : g_stk
      uart_irq_sticky #(.SET_WINS(g != 2)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stk_set[g]),
        .clr_i  (stk_clr[g]),
        .flag_o (stk_q[g])
      );
    end
  endgenerate

  assign txe_shown = (ident_q[CODE_W-1:0] == ID_TXE);

  uart_irq_thre u_thre (
    .clk     (clk),
    .rst_n   (rst_n),
    .empty_i (thr_empty),
    .en_i    (ier_q[SRC_TXE]),
    .wr_i    (thr_wr),
    .id_rd_i (ident_rd),
    .shown_i (txe_shown),
    .pend_o  (txe_pend),
    .set_o   (txe_set)
  );

  always_comb begin
    raw_pend           = '0;
    raw_pend[SRC_LINE] = stk_q[0];
    raw_pend[SRC_MDM]  = stk_q[1];
    raw_pend[SRC_RXD]  = stk_q[2];
    raw_pend[SRC_TXE]  = txe_pend;
  end

  uart_irq_rank u_rank (
    .en_i    (ier_q),
    .raw_i   (raw_pend),
    .fifo_i  (fifo_on),
    .live_o  (live_pend),
    .ident_o (ident_q)
  );

  assign irq = |live_pend;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier_q,
  input logic       line_err_evt,
  input logic       rx_avail,
  input logic       modem_delta_evt,
  input logic       fifo_on,
  input logic       ident_rd,
  input logic       line_rd,
  input logic       rbr_rd,
  input logic       modem_rd,
  input logic       thr_empty,
  input logic       thr_wr,
  input logic [7:0] ident_q,
  input logic       irq,
  input logic [3:0] raw_pend,
  input logic       txe_set
);
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rd && !line_err_evt) |=> !raw_pend[2]); // R5
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_pend[2] && !line_rd) |=> raw_pend[2]); // R5
  AST_MDM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_rd && !modem_delta_evt) |=> !raw_pend[3]); // R6
  AST_MDM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    modem_delta_evt |=> raw_pend[3]); // R6
  AST_RXD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_rd |=> !raw_pend[0]); // R7
  AST_RXD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_avail && !rbr_rd) |=> raw_pend[0]); // R7
  AST_TXE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !txe_set) |=> !raw_pend[1]); // R8
  AST_TXE_IDREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_rd && ident_q[3:0] == 4'h2 && !txe_set) |=> !raw_pend[1]); // R8
  AST_TXE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_pend[1] && thr_empty && !thr_wr && ident_q[3:0] != 4'h2) |=> raw_pend[1]); // R9
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_pend[2] && ier_q[2]) |-> ident_q[3:0] == 4'h6); // R2
  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ident_q[7:4] == (fifo_on ? 4'hC : 4'h0)); // R3
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ($countones(raw_pend & ier_q) != 0)); // R10
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(raw_pend & ier_q) == 0) |-> ident_q[3:0] == 4'h1); // R4
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ier_q           (ier_q),
  .line_err_evt    (line_err_evt),
  .rx_avail        (rx_avail),
  .modem_delta_evt (modem_delta_evt),
  .fifo_on         (fifo_on),
  .ident_rd        (ident_rd),
  .line_rd         (line_rd),
  .rbr_rd          (rbr_rd),
  .modem_rd        (modem_rd),
  .thr_empty       (thr_empty),
  .thr_wr          (thr_wr),
  .ident_q         (ident_q),
  .irq             (irq),
  .raw_pend        (raw_pend),
  .txe_set         (txe_set)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ier_q = 4'h0;
  logic       line_err_evt = 1'b0, rx_avail = 1'b0, thr_empty = 1'b1;
  logic       modem_delta_evt = 1'b0, fifo_on = 1'b0;
  logic       ident_rd = 1'b0, line_rd = 1'b0, rbr_rd = 1'b0;
  logic       modem_rd = 1'b0, thr_wr = 1'b0;
  logic [7:0] ident_q;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .ier_q(ier_q), .line_err_evt(line_err_evt),
    .rx_avail(rx_avail), .thr_empty(thr_empty), .modem_delta_evt(modem_delta_evt),
    .fifo_on(fifo_on), .ident_rd(ident_rd), .line_rd(line_rd), .rbr_rd(rbr_rd),
    .modem_rd(modem_rd), .thr_wr(thr_wr), .ident_q(ident_q), .irq(irq));

  // ---------------- behavioural reference ----------------
  bit m_line = 0, m_mdm = 0, m_rxd = 0, m_txe = 0;
  bit m_prev_empty = 0, m_prev_en = 0;

  function automatic int ref_ident(bit ln, bit rd, bit te, bit md,
                                   logic [3:0] en, bit fifo);
    int code;
    code = 1;
    if (md && en[3]) code = 0;
    if (te && en[1]) code = 2;
    if (rd && en[0]) code = 4;
    if (ln && en[2]) code = 6;
    return (fifo ? 192 : 0) + code;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = 0; m_mdm = 0; m_rxd = 0; m_txe = 0;
      m_prev_empty = 0; m_prev_en = 0;
    end else begin
      int shown;
      bit arm;
      shown = ref_ident(m_line, m_rxd, m_txe, m_mdm, ier_q, fifo_on) % 16;
      arm = thr_empty && (!m_prev_empty || (ier_q[1] && !m_prev_en));
      if (arm) m_txe = 1;
      else if (thr_wr || !thr_empty || (ident_rd && shown == 2)) m_txe = 0;
      if (line_err_evt) m_line = 1; else if (line_rd) m_line = 0;
      if (modem_delta_evt) m_mdm = 1; else if (modem_rd) m_mdm = 0;
      if (rbr_rd) m_rxd = 0; else if (rx_avail) m_rxd = 1;
      m_prev_empty = thr_empty;
      m_prev_en = ier_q[1];
    end
  end

  // continuous comparison on every falling edge: R2 R4 R10
  always @(negedge clk) begin
    int e;
    if (!done) begin
      e = ref_ident(m_line, m_rxd, m_txe, m_mdm, ier_q, fifo_on);
      n_cmp++;
      if (ident_q !== e[7:0] || irq !== (e % 2 == 0)) begin
        n_bad++;
        $display("FAIL R2 model t=%0t ident got %02h exp %02h irq got %0b exp %0b",
                 $time, ident_q, e[7:0], irq, (e % 2 == 0));
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [7:0] exp);
    #1;
    n_cmp++;
    if (ident_q !== exp || irq !== !exp[0]) begin
      n_bad++;
      $display("FAIL %s ident got %02h exp %02h irq got %0b exp %0b",
               tag, ident_q, exp, irq, !exp[0]);
    end
  endtask

  initial begin
    repeat (3) cyc();
    chk("R1 in reset", 8'h01);
    rst_n = 1'b1;
    cyc();
    chk("R1 after reset", 8'h01);
    ier_q = 4'h2;
    chk("R8 R10 first empty", 8'h02);
    cyc();
    fifo_on = 1'b1;
    chk("R3 fifo bits", 8'hC2);
    ident_rd = 1; cyc(); ident_rd = 0;
    chk("R8 ident read clears", 8'hC1);
    rx_avail = 1; ier_q = 4'h3; cyc();
    chk("R7 data pending", 8'hC4);
    rbr_rd = 1; cyc(); rbr_rd = 0;
    chk("R7 read drops", 8'hC1);
    cyc();
    chk("R7 requalify", 8'hC4);
    rx_avail = 0; cyc();
    chk("R7 held until read", 8'hC4);
    rbr_rd = 1; cyc(); rbr_rd = 0;
    chk("R7 read retires", 8'hC1);
    thr_empty = 0; cyc(); thr_empty = 1; cyc();
    chk("R8 rearm on empty", 8'hC2);
    line_err_evt = 1; ier_q = 4'h7; cyc(); line_err_evt = 0;
    chk("R5 R2 line over txe", 8'hC6);
    ident_rd = 1; cyc(); ident_rd = 0;
    chk("R9 ident read under line", 8'hC6);
    line_rd = 1; cyc(); line_rd = 0;
    chk("R9 txe survived", 8'hC2);
    modem_delta_evt = 1; ier_q = 4'hF; cyc(); modem_delta_evt = 0;
    chk("R2 txe over modem", 8'hC2);
    thr_wr = 1; thr_empty = 0; cyc(); thr_wr = 0;
    chk("R6 R8 write clears txe", 8'hC0);
    ier_q = 4'h7;
    chk("R4 modem hidden", 8'hC1);
    ier_q = 4'hF;
    chk("R4 modem kept", 8'hC0);
    modem_rd = 1; cyc(); modem_rd = 0;
    chk("R6 modem read clears", 8'hC1);
    fifo_on = 0;
    chk("R3 fifo off", 8'h01);
    line_err_evt = 1; line_rd = 1; cyc(); line_err_evt = 0; line_rd = 0;
    chk("R5 event wins over read", 8'h06);
    line_rd = 1; cyc(); line_rd = 0;
    chk("R5 line read clears", 8'h01);
    thr_empty = 1; cyc(); cyc();
    chk("R8 pending again", 8'h02);
    ident_rd = 1; cyc(); ident_rd = 0;
    chk("R8 cleared again", 8'h01);
    ier_q = 4'hD; cyc(); ier_q = 4'hF; cyc();
    chk("R8 enable rearm", 8'h02);

    // random phase, compared against the reference every cycle
    for (int i = 0; i < 4000; i++) begin
      ier_q           = 4'($urandom_range(0, 15));
      fifo_on         = ($urandom_range(0, 15) == 0) ? ~fifo_on : fifo_on;
      line_err_evt    = ($urandom_range(0, 9) == 0);
      modem_delta_evt = ($urandom_range(0, 9) == 0);
      rx_avail        = ($urandom_range(0, 3) == 0);
      thr_empty       = ($urandom_range(0, 5) != 0);
      ident_rd        = ($urandom_range(0, 3) == 0);
      line_rd         = ($urandom_range(0, 5) == 0);
      rbr_rd          = ($urandom_range(0, 4) == 0);
      modem_rd        = ($urandom_range(0, 5) == 0);
      thr_wr          = ($urandom_range(0, 7) == 0);
      cyc();
    end
    cyc();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule